// File: doc/BRIEF.md
# Command Response Capture with Halfword Readout

This block listens to the card's command line on the card clock and captures the response that follows a command. Software starts it with a strobe and a 3-bit response-type code. The block then waits for the start bit (a 0) and shifts the frame in MSB first. It stops after 48 bits for a short response or 136 bits for a long one. Once the response is complete, it raises a one-cycle end pulse, a CRC error flag where that applies, or a timeout flag if no start bit arrived in time.

Software reads the captured response from one 16-bit port, one halfword per read. The halfwords run across byte boundaries. A 32-bit response word is rebuilt from the low byte of one halfword, the whole of the next, and the high byte of the one after that. A short response takes three reads. A long response takes nine, and the first of those carries only one useful byte, in its low half.

Top module: `rsp_capture`

## Requirements
- R1: `rsp_kind` at the `start` strobe selects the response: 1 = 48-bit with CRC check, 3 = 48-bit without CRC check, 2 = 136-bit without CRC check. Code 0 and codes 4 to 7 mean no response: `rsp_done` pulses in the cycle after the strobe, both flags stay 0 and no halfword becomes readable.
- R2: After the strobe the block samples `cmd_in` on each rising edge. A 0 sampled in any of the first `to_limit` samples is taken as the start bit and becomes frame bit 0. `to_limit` must be at least 1.
- R3: For a 48-bit frame f[47:0] (f[47] = start bit), the three readable halfwords are f[47:32], f[31:16] and f[15:0], in that order.
- R4: For a 136-bit frame f[135:0], define e = {f, 8'h00}. The nine readable halfwords are e[143:128], e[127:112], …, e[15:0]. The first halfword's low byte is f[127:120].
- R5: `rsp_done` is a single-cycle pulse. It is high in the cycle after the edge that samples the last frame bit, or the edge that declares a timeout.
- R6: For code 1 only, the CRC7 (x^7+x^3+1, register initialised to 0, MSB first) of f[47:8] is compared with f[7:1]. A mismatch sets `crc_err` along with `rsp_done`. Codes 2 and 3 never set `crc_err`.
- R7: If all of the first `to_limit` samples are 1, `timeout_err` is set together with `rsp_done`. No halfword becomes readable.
- R8: `rd_data` shows the halfword at the read pointer. Each cycle with `rd_en` high advances the pointer. Once the pointer has passed the last halfword, and before any response completes, `rd_data` is 0.
- R9: A `start` strobe clears both flags and the read pointer and restarts capture, even when a capture is in progress. Only the restarted capture produces `rsp_done`.
- R10: After reset, `rd_data`, `rsp_done`, `crc_err` and `timeout_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | Command line from the card |
| rsp_kind | input | 3 | Response-type code, sampled with `start` |
| start | input | 1 | Begin capture strobe |
| to_limit | input | TO_W | Start-bit wait window in clock cycles |
| rd_en | input | 1 | Pop the current halfword |
| rd_data | output | 16 | Current halfword |
| rsp_done | output | 1 | End-of-response pulse |
| crc_err | output | 1 | Response CRC mismatch |
| timeout_err | output | 1 | No start bit within the window |

## Verification
The strobe is taken at edge 0, and the wait window opens at edge 1. A start bit presented before edge 1+d is accepted when d < `to_limit`. `rsp_done` and the flags become visible after the edge that samples the last frame bit, or after edge `to_limit` in the timeout case. For code 0 they appear after edge 0. The bench drives stimulus just after a rising edge and samples on the falling edge. At each `rsp_done` the monitor pops the queued flag expectation, so a pulse in any other cycle finds an empty queue and fails. Halfword reads are compared in the same cycle as `rd_en`, because the port shows the current halfword ahead of the pop.

// File: rtl/rsp_capture.sv
module rsp_capture #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_in,
  input  logic [2:0]      rsp_kind,
  input  logic            start,
  input  logic [TO_W-1:0] to_limit,
  input  logic            rd_en,
  output logic [15:0]     rd_data,
  output logic            rsp_done,
  output logic            crc_err,
  output logic            timeout_err
);
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int CRC_SPAN   = 40;
  localparam int EXT_W      = 144;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} state_t;

  state_t               state;
  logic [LONG_BITS-1:0] sr;
  logic [7:0]           bitcnt;
  logic [TO_W-1:0]      tcnt;
  logic [6:0]           crc;
  logic                 is_long, chk_crc;
  logic [3:0]           ptr, nhw;

  logic       fb;
  logic [6:0] crc_nxt;
  logic [7:0] last_idx;
  logic [EXT_W-1:0] ext, ext_sh;

  assign fb       = cmd_in ^ crc[6];
  assign crc_nxt  = {crc[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
  assign last_idx = is_long ? 8'(LONG_BITS - 1) : 8'(SHORT_BITS - 1);
  assign ext      = is_long ? {sr, 8'h00} : {sr[SHORT_BITS-1:0], {(EXT_W-SHORT_BITS){1'b0}}};
  assign ext_sh   = ext << {ptr, 4'b0000};
  assign rd_data  = (ptr < nhw) ? ext_sh[EXT_W-1 -: 16] : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      sr          <= '0;
      bitcnt      <= '0;
      tcnt        <= '0;
      crc         <= '0;
      is_long     <= 1'b0;
      chk_crc     <= 1'b0;
      ptr         <= '0;
      nhw         <= '0;
      rsp_done    <= 1'b0;
      crc_err     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (rd_en && ptr < nhw) ptr <= ptr + 4'd1;
      if (start) begin
        ptr         <= '0;
        nhw         <= '0;
        crc_err     <= 1'b0;
        timeout_err <= 1'b0;
        tcnt        <= '0;
        crc         <= '0;
        bitcnt      <= '0;
        is_long     <= (rsp_kind == 3'd2);
        chk_crc     <= (rsp_kind == 3'd1);
        if (rsp_kind == 3'd1 || rsp_kind == 3'd2 || rsp_kind == 3'd3) begin
          state <= S_WAIT;
        end else begin
          state    <= S_IDLE;
          rsp_done <= 1'b1;
        end
      end else begin
        case (state)
          S_WAIT: begin
            if (!cmd_in) begin
              state  <= S_SHIFT;
              sr     <= {sr[LONG_BITS-2:0], 1'b0};
              bitcnt <= 8'd1;
              crc    <= crc_nxt;
            end else if (tcnt == to_limit - 1'b1) begin
              timeout_err <= 1'b1;
              rsp_done    <= 1'b1;
              state       <= S_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          S_SHIFT: begin
            sr     <= {sr[LONG_BITS-2:0], cmd_in};
            bitcnt <= bitcnt + 8'd1;
            if (bitcnt < 8'(CRC_SPAN)) crc <= crc_nxt;
            if (bitcnt == last_idx) begin
              state    <= S_IDLE;
              rsp_done <= 1'b1;
              nhw      <= is_long ? 4'd9 : 4'd3;
              crc_err  <= chk_crc && (crc != sr[6:0]);
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rsp_capture_chk.sv
module rsp_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        rsp_done,
  input logic        crc_err,
  input logic        timeout_err,
  input logic [3:0]  ptr,
  input logic [3:0]  nhw,
  input logic        chk_crc
);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done || $past(start)));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_err && timeout_err));

  assert_timeout_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> rsp_done);

  assert_crc_only_code1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> (chk_crc && rsp_done));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!crc_err && !timeout_err && rd_data == 16'h0000));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !start && ptr < nhw) |=> (ptr == $past(ptr) + 4'd1));
endmodule

bind rsp_capture rsp_capture_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_data(rd_data),
  .rsp_done(rsp_done), .crc_err(crc_err), .timeout_err(timeout_err),
  .ptr(ptr), .nhw(nhw), .chk_crc(chk_crc)
);

// File: tb/test_rsp_capture.sv
module test_rsp_capture;
  localparam int TO_W = 16;
  localparam int LIM  = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cmd_in = 1'b1, start = 1'b0, rd_en = 1'b0;
  logic [2:0] rsp_kind = 3'd0;
  logic [TO_W-1:0] to_limit = TO_W'(LIM);
  logic [15:0] rd_data;
  logic rsp_done, crc_err, timeout_err;

  rsp_capture #(.TO_W(TO_W)) i_rsp_capture (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .rsp_kind(rsp_kind), .start(start),
    .to_limit(to_limit), .rd_en(rd_en), .rd_data(rd_data), .rsp_done(rsp_done),
    .crc_err(crc_err), .timeout_err(timeout_err));

  int n_chk = 0, n_fail = 0;
  logic [15:0] hw_q[$];
  string       hw_tag_q[$];
  logic [1:0]  fl_q[$];
  string       fl_tag_q[$];
  bit          done_flag = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rd_en) begin
      if (hw_q.size() == 0) check(0, "R8", "unexpected read", {16'h0, rd_data}, 32'h0);
      else begin
        logic [15:0] e;
        string t;
        e = hw_q.pop_front();
        t = hw_tag_q.pop_front();
        check(rd_data == e, t, "halfword", {16'h0, rd_data}, {16'h0, e});
      end
    end
    if (rsp_done) begin
      if (fl_q.size() == 0) check(0, "R5", "spurious done pulse", 32'h1, 32'h0);
      else begin
        logic [1:0] e;
        string t;
        e = fl_q.pop_front();
        t = fl_tag_q.pop_front();
        check({crc_err, timeout_err} == e, t, "flags {crc,timeout}",
              {30'h0, crc_err, timeout_err}, {30'h0, e});
      end
    end
  end

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = 7'h00;
    for (int i = 39; i >= 0; i--) begin
      logic f;
      f = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (f) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] short_frame(input logic [5:0] idx, input logic [31:0] arg,
                                              input bit bad);
    logic [47:0] f;
    f = {2'b00, idx, arg, 7'h00, 1'b1};
    f[7:1] = crc7(f[47:8]);
    if (bad) f[1] = ~f[1];
    return f;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic kick(input logic [2:0] k);
    rsp_kind = k; start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic send(input logic [135:0] bits, input int n, input int delay);
    cmd_in = 1'b1;
    repeat (delay) tick();
    for (int i = n - 1; i >= 0; i--) begin cmd_in = bits[i]; tick(); end
    cmd_in = 1'b1;
  endtask

  task automatic expect_flags(input bit c, input bit t, input string tag);
    fl_q.push_back({c, t}); fl_tag_q.push_back(tag);
  endtask

  task automatic read_all(input logic [143:0] ext, input int nvalid, input int total,
                          input string tag);
    for (int k = 0; k < total; k++) begin
      logic [143:0] s;
      s = ext << (16 * k);
      hw_q.push_back(k < nvalid ? s[143:128] : 16'h0000);
      hw_tag_q.push_back(k < nvalid ? tag : "R8");
      rd_en = 1'b1; tick();
    end
    rd_en = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [47:0] f;
    logic [135:0] lf;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'h0 && !rsp_done && !crc_err && !timeout_err, "R10", "reset outputs",
          {13'h0, rsp_done, crc_err, timeout_err, rd_data}, 32'h0);
    tick();

    // R3: good short frame, CRC checked
    f = short_frame(6'h11, 32'hDEAD_BEEF, 0);
    expect_flags(0, 0, "R3");
    kick(3'd1); send({88'h0, f}, 48, 3); tick();
    read_all({f, 96'h0}, 3, 5, "R3");

    // R6: corrupted CRC with code 1
    f = short_frame(6'h2A, 32'h1234_5678, 1);
    expect_flags(1, 0, "R6");
    kick(3'd1); send({88'h0, f}, 48, 0); tick();
    read_all({f, 96'h0}, 3, 3, "R6");

    // R1: code 3, bad CRC not flagged
    f = short_frame(6'h3F, 32'h00FF_00FF, 1);
    expect_flags(0, 0, "R1");
    kick(3'd3); send({88'h0, f}, 48, 5); tick();
    read_all({f, 96'h0}, 3, 4, "R1");

    // R4: long frame
    lf = {2'b00, 6'h3F, 127'h5A5A_1234_9876_ABCD_0F0F_F0F0_C3C3_7E7E, 1'b1};
    expect_flags(0, 0, "R4");
    kick(3'd2); send(lf, 136, 2); tick();
    read_all({lf, 8'h00}, 9, 10, "R4");

    // R1: no-response codes
    expect_flags(0, 0, "R1");
    kick(3'd0); tick();
    read_all(144'h0, 0, 2, "R1");
    expect_flags(0, 0, "R1");
    kick(3'd5); tick();
    read_all(144'h0, 0, 1, "R1");

    // R2: start bit in the last sample of the window
    f = short_frame(6'h05, 32'hCAFE_F00D, 0);
    expect_flags(0, 0, "R2");
    kick(3'd1); send({88'h0, f}, 48, LIM - 1); tick();
    read_all({f, 96'h0}, 3, 3, "R2");

    // R7: timeout one sample later
    expect_flags(0, 1, "R7");
    kick(3'd1); cmd_in = 1'b1; repeat (LIM + 2) tick();
    read_all(144'h0, 0, 2, "R7");

    // R9: restart mid-wait, flags cleared, single done
    f = short_frame(6'h09, 32'h8000_0001, 0);
    expect_flags(0, 0, "R9");
    kick(3'd1); repeat (4) tick();
    kick(3'd1); send({88'h0, f}, 48, 1); tick();
    read_all({f, 96'h0}, 3, 4, "R9");

    repeat (5) tick();
    check(fl_q.size() == 0, "R5", "missing done pulses", fl_q.size(), 0);
    finish_up();
  end
endmodule